// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block takes a vector of pin values that have already been synchronised and filtered further up the input path. For each pin it raises an interrupt status bit. Each pin can arm four trigger types on its own: a rising edge, a falling edge, a high level and a low level. When any armed trigger fires, the pin's status bit is set. The bit stays set until software clears it.

Software clears status bits by writing a mask of ones. A test write port sets chosen status bits directly, so that the interrupt path can be exercised without moving any pins. A per-pin enable mask decides which status bits reach the interrupt lines. Each interrupt line is the registered AND of the status bit and its enable bit.

An edge is found by comparing the present sample with the sample held from the previous cycle. The first sample after reset has no previous sample, so it never counts as an edge.

Top module: `gpio_evt_detect`

## Requirements
- R1: While reset is asserted and right after it is released, `status_o` and `irq_o` are all zero.
- R2: With `rise_en_i[k]` set, pin k reading 0 in one cycle and 1 in the next sets `status_o[k]` at the clock edge that samples the 1. The first sample after reset is never treated as an edge.
- R3: With `fall_en_i[k]` set, pin k reading 1 in one cycle and 0 in the next sets `status_o[k]` at the clock edge that samples the 0.
- R4: With `high_en_i[k]` set, every clock edge that samples pin k at 1 sets `status_o[k]`.
- R5: With `low_en_i[k]` set, every clock edge that samples pin k at 0 sets `status_o[k]`.
- R6: A trigger type whose enable bit is 0 never sets the status bit, whatever the pin does.
- R7: A status bit stays set until a cycle with `clr_we_i` high and a 1 in its position of `clr_mask_i`. At that edge it clears. Zeros in `clr_mask_i` leave their bits alone.
- R8: If an armed trigger fires on a pin in the same cycle as a clear of that pin, the status bit stays set. A level that is still present therefore keeps its bit set through a clear.
- R9: A cycle with `test_we_i` high sets every status bit that has a 1 in `test_mask_i`. This happens whatever the trigger enables are, and also when a clear of the same bit arrives in that cycle.
- R10: `irq_o[k]` equals `status_o[k] & irq_en_i[k]` as sampled at the previous clock edge, so it lags the status by one cycle.
- R11: Each pin's detection, status and interrupt depend only on that pin's own input and enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | NPINS | Sampled pin values |
| rise_en_i | input | NPINS | Per-pin rising-edge trigger enable |
| fall_en_i | input | NPINS | Per-pin falling-edge trigger enable |
| high_en_i | input | NPINS | Per-pin high-level trigger enable |
| low_en_i | input | NPINS | Per-pin low-level trigger enable |
| irq_en_i | input | NPINS | Per-pin interrupt line enable |
| clr_we_i | input | 1 | Strobe for the write-one-to-clear mask |
| clr_mask_i | input | NPINS | Bits to clear |
| test_we_i | input | 1 | Strobe for the test-set mask |
| test_mask_i | input | NPINS | Bits to force set |
| status_o | output | NPINS | Sticky interrupt status |
| irq_o | output | NPINS | Registered, enabled interrupt lines |

## Verification
A trigger, a clear or a test write that is presented in one cycle shows up in `status_o` right after the next rising edge. It then reaches `irq_o` one edge after that. The bench drives every stimulus on the falling edge and reads `status_o` at the following falling edge, one register later. It reads `irq_o` a further cycle on, so each result is checked in the cycle it becomes due. The sweep first loads the previous-sample register with one clearing cycle and only then applies the pattern under test. This makes the edge history of every pin known exactly.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
    logic high;
    logic low;
  } trig_cfg_t;

  // Single-pin trigger evaluation: edges need a valid history sample.
  function automatic logic pin_event(logic prev, logic cur, logic hist_ok, trig_cfg_t cfg);
    logic rose;
    logic fell;
    rose = hist_ok & ~prev & cur;
    fell = hist_ok & prev & ~cur;
    return (cfg.rise & rose) | (cfg.fall & fell) | (cfg.high & cur) | (cfg.low & ~cur);
  endfunction

  // Single-pin status update: set sources beat a clear.
  function automatic logic status_next(logic cur_st, logic evt, logic clr, logic tst);
    return evt | tst | (cur_st & ~clr);
  endfunction

endpackage

// File: rtl/gpio_evt_history.sv
module gpio_evt_history #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] prev_o,
  output logic             hist_ok_o
);

  logic [NPINS-1:0] prev_q;
  logic             ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      ok_q   <= 1'b0;
    end else begin
      prev_q <= pin_i;
      ok_q   <= 1'b1;
    end
  end

  assign prev_o    = prev_q;
  assign hist_ok_o = ok_q;

endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status
  import gpio_evt_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] prev_i,
  input  logic             hist_ok_i,
  input  logic [NPINS-1:0] rise_en_i,
  input  logic [NPINS-1:0] fall_en_i,
  input  logic [NPINS-1:0] high_en_i,
  input  logic [NPINS-1:0] low_en_i,
  input  logic [NPINS-1:0] clr_bits_i,
  input  logic [NPINS-1:0] test_bits_i,
  output logic [NPINS-1:0] evt_o,
  output logic [NPINS-1:0] status_o
);

  logic [NPINS-1:0] st_q;

  for (genvar k = 0; k < NPINS; k++) begin : g_pin
    trig_cfg_t cfg;
    logic      evt;

    always_comb begin
      cfg.rise = rise_en_i[k];
      cfg.fall = fall_en_i[k];
      cfg.high = high_en_i[k];
      cfg.low  = low_en_i[k];
      evt      = pin_event(prev_i[k], pin_i[k], hist_ok_i, cfg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[k] <= 1'b0;
      else        st_q[k] <= status_next(st_q[k], evt, clr_bits_i[k], test_bits_i[k]);
    end

    assign evt_o[k] = evt;
  end

  assign status_o = st_q;

endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] status_i,
  input  logic [NPINS-1:0] irq_en_i,
  output logic [NPINS-1:0] irq_o
);

  logic [NPINS-1:0] irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= status_i & irq_en_i;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] rise_en_i,
  input  logic [NPINS-1:0] fall_en_i,
  input  logic [NPINS-1:0] high_en_i,
  input  logic [NPINS-1:0] low_en_i,
  input  logic [NPINS-1:0] irq_en_i,
  input  logic             clr_we_i,
  input  logic [NPINS-1:0] clr_mask_i,
  input  logic             test_we_i,
  input  logic [NPINS-1:0] test_mask_i,
  output logic [NPINS-1:0] status_o,
  output logic [NPINS-1:0] irq_o
);

  // Named internal events, visible to the bound checker.
  logic [NPINS-1:0] prev_w;
  logic             hist_ok_w;
  logic [NPINS-1:0] evt_w;
  logic [NPINS-1:0] clr_bits_w;
  logic [NPINS-1:0] test_bits_w;
  logic [NPINS-1:0] status_w;

  assign clr_bits_w  = clr_we_i  ? clr_mask_i  : '0;
  assign test_bits_w = test_we_i ? test_mask_i : '0;

  gpio_evt_history #(.NPINS(NPINS)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin_i),
    .prev_o    (prev_w),
    .hist_ok_o (hist_ok_w)
  );

  gpio_evt_status #(.NPINS(NPINS)) u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin_i),
    .prev_i      (prev_w),
    .hist_ok_i   (hist_ok_w),
    .rise_en_i   (rise_en_i),
    .fall_en_i   (fall_en_i),
    .high_en_i   (high_en_i),
    .low_en_i    (low_en_i),
    .clr_bits_i  (clr_bits_w),
    .test_bits_i (test_bits_w),
    .evt_o       (evt_w),
    .status_o    (status_w)
  );

  gpio_evt_irq #(.NPINS(NPINS)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status_w),
    .irq_en_i (irq_en_i),
    .irq_o    (irq_o)
  );

  assign status_o = status_w;

endmodule

// File: rtl/gpio_evt_checker.sv
module gpio_evt_checker #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] evt_i,
  input logic [NPINS-1:0] clr_bits_i,
  input logic [NPINS-1:0] test_bits_i,
  input logic [NPINS-1:0] irq_en_i,
  input logic [NPINS-1:0] status_i,
  input logic [NPINS-1:0] irq_i
);

  // R7: a set bit that was not cleared stays set
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_i) & ~$past(clr_bits_i)) & ~status_i) == '0);

  // R7: a cleared bit with no set source drops
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_i & $past(clr_bits_i & ~evt_i & ~test_bits_i)) == '0);

  // R8: a fired trigger always leaves its bit set, clear or not
  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_i) & ~status_i) == '0);

  // R9: forced bits are set after the edge
  p_test_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(test_bits_i) & ~status_i) == '0);

  // R6: no bit rises without a trigger or a test write
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_i & ~$past(status_i) & ~$past(evt_i | test_bits_i)) == '0);

  // R10: interrupt lines are the gated status one edge late
  p_irq_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i == $past(status_i & irq_en_i));

  // R1: outputs are clear while in reset
  always_comb begin
    if (!rst_n) begin
      a_reset_r1: assert (status_i == '0 && irq_i == '0);
    end
  end

endmodule

bind gpio_evt_detect gpio_evt_checker #(.NPINS(NPINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_i       (evt_w),
  .clr_bits_i  (clr_bits_w),
  .test_bits_i (test_bits_w),
  .irq_en_i    (irq_en_i),
  .status_i    (status_o),
  .irq_i       (irq_o)
);

// File: tb/sim_gpio_evt_detect.sv
module sim_gpio_evt_detect;

  localparam int N = 32;
  localparam logic [N-1:0] IRQ_MASK = 32'hC3C3_5A5A;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0, ren = '0, fen = '0, hen = '0, len = '0, ien = '0;
  logic         clr_we = 1'b0, test_we = 1'b0;
  logic [N-1:0] clr_mask = '0, test_mask = '0;
  logic [N-1:0] status, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_evt_detect #(.NPINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin),
    .rise_en_i(ren), .fall_en_i(fen), .high_en_i(hen), .low_en_i(len),
    .irq_en_i(ien), .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .test_we_i(test_we), .test_mask_i(test_mask),
    .status_o(status), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R1 reset state, with rising triggers armed and pins high (R2 history)
    pin = '1;
    ren = '1;
    ien = '1;
    repeat (2) @(negedge clk);
    chk("R1 status in reset", status, '0);
    chk("R1 irq in reset", irq, '0);
    rst_n = 1'b1;
    tick();
    chk("R2 first sample is no edge", status, '0);
    tick();
    chk("R1 irq after reset", irq, '0);
    pin = '0;
    tick();
    pin = 32'h0000_FFFF;
    tick();
    chk("R2 rising edge sets", status, 32'h0000_FFFF);
    ren = '0;
    clr_we = 1'b1;
    clr_mask = '1;
    tick();
    clr_we = 1'b0;
    chk("R7 clear all", status, '0);

    // Sweep: each pin gets its own enable combo and its own transition (R2-R6, R11)
    ien = IRQ_MASK;
    for (int tr = 0; tr < 4; tr++) begin
      for (int rot = 0; rot < 16; rot++) begin
        logic [N-1:0] pv, cv, r, f, h, l, exp;
        for (int i = 0; i < N; i++) begin
          int c;
          int t;
          c = (i + rot) % 16;
          t = ((i / 16) + tr + i) % 4;
          pv[i] = t[1];
          cv[i] = t[0];
          r[i] = c[0];
          f[i] = c[1];
          h[i] = c[2];
          l[i] = c[3];
          exp[i] = (r[i] & ~pv[i] & cv[i]) | (f[i] & pv[i] & ~cv[i])
                 | (h[i] & cv[i]) | (l[i] & ~cv[i]);
        end
        ren = '0; fen = '0; hen = '0; len = '0;
        pin = pv;
        clr_we = 1'b1;
        clr_mask = '1;
        tick();
        clr_we = 1'b0;
        ren = r; fen = f; hen = h; len = l;
        pin = cv;
        tick();
        chk("R2 R3 R4 R5 R6 R11 sweep status", status, exp);
        ren = '0; fen = '0; hen = '0; len = '0;
        tick();
        chk("R10 R11 sweep irq", irq, exp & IRQ_MASK);
      end
    end

    // R9 test force, then R7 stickiness and partial clear
    ien = '0;
    clr_we = 1'b1;
    clr_mask = '1;
    tick();
    clr_we = 1'b0;
    test_we = 1'b1;
    test_mask = 32'hA5A5_A5A5;
    tick();
    test_we = 1'b0;
    chk("R9 test set", status, 32'hA5A5_A5A5);
    repeat (3) tick();
    chk("R7 sticky", status, 32'hA5A5_A5A5);
    clr_we = 1'b1;
    clr_mask = 32'h0000_FFFF;
    tick();
    clr_we = 1'b0;
    chk("R7 partial clear", status, 32'hA5A5_0000);

    // R8 level still present survives a clear
    pin = 32'h0F0F_0F0F;
    hen = '1;
    clr_we = 1'b1;
    clr_mask = '1;
    tick();
    chk("R8 level holds through clear", status, 32'h0F0F_0F0F);
    tick();
    chk("R8 level re-sets each cycle", status, 32'h0F0F_0F0F);
    hen = '0;
    tick();
    clr_we = 1'b0;
    chk("R7 clear once level off", status, '0);

    // R9 test beats a simultaneous clear
    clr_we = 1'b1;
    clr_mask = '1;
    test_we = 1'b1;
    test_mask = 32'h0000_0003;
    tick();
    clr_we = 1'b0;
    test_we = 1'b0;
    chk("R9 test beats clear", status, 32'h0000_0003);

    // R10 one-cycle lag and gating
    ien = '1;
    test_we = 1'b1;
    test_mask = 32'h0000_0010;
    tick();
    test_we = 1'b0;
    chk("R10 irq lags status", irq, 32'h0000_0003);
    tick();
    chk("R10 irq follows", irq, 32'h0000_0013);
    ien = 32'h0000_0010;
    tick();
    chk("R10 irq gated", irq, 32'h0000_0010);

    // R3 falling edge alone on a single pin (R11)
    ien = '0;
    clr_we = 1'b1;
    clr_mask = '1;
    pin = 32'h8000_0001;
    tick();
    clr_we = 1'b0;
    fen = '1;
    pin = 32'h0000_0001;
    tick();
    chk("R3 R11 single falling edge", status, 32'h8000_0000);
    fen = '0;

    finish_run();
  end

endmodule